// File: doc/BRIEF.md
# Vector Mask First-Set Prefix Unit

This unit takes a source mask vector and builds a new destination mask from the position of its lowest set bit. Element 0 is the least significant bit, and the search runs upward from it. An optional predicate vector decides which elements take part. The search sees only source bits at active positions. Only active destination elements are rewritten; the others keep the old destination value supplied with the request.

A 2-bit operation select picks one of three related prefix shapes. In fill-below mode, active elements under the first set bit become 1. Fill-through mode does the same and also sets the first set bit itself. Isolate mode marks only the first set bit. A fourth code returns the old destination unchanged. A single log-depth prefix search feeds all three shapes.

The result is registered. It appears one clock after a single-cycle request strobe, together with a one-cycle output valid pulse. The registered destination holds its value between requests.

Top module: `vmask_prefix_unit`

## Requirements
- R1: With `op_sel` = 2'b00 (fill-below), each active element whose index is below the first active source 1 is written 1. The element holding that 1, and every active element above it, is written 0.
- R2: With `op_sel` = 2'b01 (fill-through), the result matches fill-below, except that the element holding the first active source 1 is written 1.
- R3: With `op_sel` = 2'b10 (isolate), only the element holding the first active source 1 is written 1, and every other active element is written 0.
- R4: When no active source bit is set, fill-below and fill-through write 1 to every active element, and isolate writes 0 to every active element.
- R5: With `pred_en` = 1, an element whose `pred` bit is 0 takes its value from `old_dst`.
- R6: The search for the first 1 skips source bits at positions whose `pred` bit is 0 while `pred_en` = 1.
- R7: With `pred_en` = 0, every element is active and `pred` has no effect.
- R8: With `op_sel` = 2'b11, `dst` equals `old_dst` in every element.
- R9: `dst` and `out_valid` change on the clock edge that samples `in_valid` = 1. `out_valid` is high for exactly one cycle per request. `dst` holds its value while `in_valid` is 0.
- R10: While `rst_n` is low, `out_valid` is 0 and `dst` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe, one cycle per operation |
| op_sel | input | 2 | 00 fill-below, 01 fill-through, 10 isolate, 11 keep |
| pred_en | input | 1 | 1: use `pred` as the active mask; 0: all elements active |
| pred | input | NUM_EL | Predicate mask, bit i covers element i |
| src | input | NUM_EL | Source mask, element 0 is bit 0 |
| old_dst | input | NUM_EL | Prior destination value |
| out_valid | output | 1 | One-cycle result strobe |
| dst | output | NUM_EL | Registered new destination mask |

## Verification
The bench drives sources whose first set bit is at element 0, at the top element, or nowhere. A prefix that is off by one at either end, or that wraps around, then shows up as a wrong edge bit. It also hides the true lowest source bit behind a cleared predicate bit. A design that searches the raw source would stop at the hidden bit instead of the next active one. Dense random predicates paired with random old destinations catch a design that writes zeros into inactive elements instead of keeping the old values. Gaps between requests catch a valid strobe that sticks high, or a destination that drifts while idle.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
  typedef enum logic [1:0] {
    OP_FILL_BELOW   = 2'b00,
    OP_FILL_THROUGH = 2'b01,
    OP_ISOLATE      = 2'b10,
    OP_KEEP         = 2'b11
  } vmask_op_e;
endpackage

// File: rtl/vmask_active.sv
// Forms the active-element mask and the source bits visible to the search.
module vmask_active #(
  parameter int NUM_EL = 64
) (
  input  logic              pred_en,
  input  logic [NUM_EL-1:0] pred,
  input  logic [NUM_EL-1:0] src,
  output logic [NUM_EL-1:0] active,
  output logic [NUM_EL-1:0] vis_src
);
  always_comb begin
    active  = pred_en ? pred : {NUM_EL{1'b1}};
    vis_src = src & active;
  end
endmodule

// File: rtl/vmask_first_find.sv
// Log-depth inclusive OR prefix. below[i] is 1 when no visible bit exists
// under element i; first is the one-hot lowest visible bit.
module vmask_first_find #(
  parameter int NUM_EL = 64
) (
  input  logic [NUM_EL-1:0] vis_src,
  output logic [NUM_EL-1:0] below,
  output logic [NUM_EL-1:0] first
);
  localparam int LEVELS = (NUM_EL > 1) ? $clog2(NUM_EL) : 1;

  logic [LEVELS:0][NUM_EL-1:0] pfx;
  logic [NUM_EL-1:0]           seen_excl;

  assign pfx[0] = vis_src;

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    for (genvar i = 0; i < NUM_EL; i++) begin : g_bit
      if (i >= (1 << k)) begin : g_comb
        assign pfx[k+1][i] = pfx[k][i] | pfx[k][i-(1<<k)];
      end else begin : g_pass
        assign pfx[k+1][i] = pfx[k][i];
      end
    end
  end

  assign seen_excl[0] = 1'b0;
  for (genvar i = 1; i < NUM_EL; i++) begin : g_excl
    assign seen_excl[i] = pfx[LEVELS][i-1];
  end

  always_comb begin
    below = ~seen_excl;
    first = vis_src & below;
  end
endmodule

// File: rtl/vmask_merge.sv
// Picks the prefix shape for the operation and merges under the active mask.
module vmask_merge
  import vmask_pkg::*;
#(
  parameter int NUM_EL = 64
) (
  input  vmask_op_e         op,
  input  logic [NUM_EL-1:0] active,
  input  logic [NUM_EL-1:0] below,
  input  logic [NUM_EL-1:0] first,
  input  logic [NUM_EL-1:0] old_dst,
  output logic [NUM_EL-1:0] new_dst
);
  logic [NUM_EL-1:0] shape;
  logic [NUM_EL-1:0] wr_mask;

  always_comb begin
    unique case (op)
      OP_FILL_BELOW:   shape = below & ~first;
      OP_FILL_THROUGH: shape = below;
      OP_ISOLATE:      shape = first;
      default:         shape = old_dst;
    endcase
    wr_mask = (op == OP_KEEP) ? '0 : active;
    new_dst = (shape & wr_mask) | (old_dst & ~wr_mask);
  end
endmodule

// File: rtl/vmask_prefix_unit.sv
module vmask_prefix_unit
  import vmask_pkg::*;
#(
  parameter int NUM_EL = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op_sel,
  input  logic              pred_en,
  input  logic [NUM_EL-1:0] pred,
  input  logic [NUM_EL-1:0] src,
  input  logic [NUM_EL-1:0] old_dst,
  output logic              out_valid,
  output logic [NUM_EL-1:0] dst
);
  logic [NUM_EL-1:0] active;
  logic [NUM_EL-1:0] vis_src;
  logic [NUM_EL-1:0] below;
  logic [NUM_EL-1:0] first;
  logic [NUM_EL-1:0] merged;
  vmask_op_e         op;

  logic [NUM_EL-1:0] dst_d, dst_q;
  logic              vld_d, vld_q;

  assign op = vmask_op_e'(op_sel);

  vmask_active #(.NUM_EL(NUM_EL)) u_active (
    .pred_en (pred_en),
    .pred    (pred),
    .src     (src),
    .active  (active),
    .vis_src (vis_src)
  );

  vmask_first_find #(.NUM_EL(NUM_EL)) u_find (
    .vis_src (vis_src),
    .below   (below),
    .first   (first)
  );

  vmask_merge #(.NUM_EL(NUM_EL)) u_merge (
    .op      (op),
    .active  (active),
    .below   (below),
    .first   (first),
    .old_dst (old_dst),
    .new_dst (merged)
  );

  always_comb begin
    vld_d = in_valid;
    dst_d = in_valid ? merged : dst_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dst_q <= '0;
    end else begin
      vld_q <= vld_d;
      dst_q <= dst_d;
    end
  end

  assign out_valid = vld_q;
  assign dst       = dst_q;
endmodule

// File: rtl/vmask_prefix_chk.sv
module vmask_prefix_chk #(
  parameter int NUM_EL = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        op_sel,
  input logic              pred_en,
  input logic [NUM_EL-1:0] pred,
  input logic [NUM_EL-1:0] old_dst,
  input logic              out_valid,
  input logic [NUM_EL-1:0] dst
);
  // R9
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R9
  dst_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dst));

  // R8
  keep_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b11) |=> dst == $past(old_dst));

  // R5
  inactive_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred_en) |=> ((dst ^ $past(old_dst)) & ~$past(pred)) == '0);

  // R3
  isolate_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pred_en && op_sel == 2'b10) |=> $onehot0(dst));
endmodule

bind vmask_prefix_unit vmask_prefix_chk #(.NUM_EL(NUM_EL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_sel    (op_sel),
  .pred_en   (pred_en),
  .pred      (pred),
  .old_dst   (old_dst),
  .out_valid (out_valid),
  .dst       (dst)
);

// File: tb/vmask_prefix_unit_test.sv
`timescale 1ns/1ps
module vmask_prefix_unit_test;
  localparam int N = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   op_sel = 2'b00;
  logic         pred_en = 1'b0;
  logic [N-1:0] pred = '0;
  logic [N-1:0] src = '0;
  logic [N-1:0] old_dst = '0;
  logic         out_valid;
  logic [N-1:0] dst;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 0;
  logic [N-1:0] exp_dst;
  logic         exp_vld;
  string        exp_tag;

  always #4 clk = ~clk;

  vmask_prefix_unit #(.NUM_EL(N)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .pred_en(pred_en), .pred(pred), .src(src), .old_dst(old_dst),
    .out_valid(out_valid), .dst(dst)
  );

  function automatic logic [N-1:0] model(input logic [1:0] op, input logic pe,
      input logic [N-1:0] pr, input logic [N-1:0] s, input logic [N-1:0] old);
    int fpos = -1;
    logic [N-1:0] r;
    for (int i = 0; i < N; i++)
      if ((!pe || pr[i]) && s[i] && fpos < 0) fpos = i;
    for (int i = 0; i < N; i++) begin
      if ((pe && !pr[i]) || op == 2'b11) r[i] = old[i];
      else if (op == 2'b00) r[i] = (fpos < 0) || (i < fpos);
      else if (op == 2'b01) r[i] = (fpos < 0) || (i <= fpos);
      else r[i] = (i == fpos);
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [1:0] op, input logic pe,
      input logic [N-1:0] pr, input logic [N-1:0] s);
    string t;
    logic [N-1:0] act = pe ? pr : {N{1'b1}};
    case (op)
      2'b00: t = "R1";
      2'b01: t = "R2";
      2'b10: t = "R3";
      default: t = "R8";
    endcase
    if (op != 2'b11 && (s & act) == '0) t = {t, "/R4"};
    if (pe) t = {t, "/R5/R6"};
    else    t = {t, "/R7"};
    return t;
  endfunction

  // Reference state, advanced on each rising edge from the driven inputs.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_vld <= 1'b0;
      exp_dst <= '0;
      exp_tag <= "R10";
    end else begin
      exp_vld <= in_valid;
      if (in_valid) begin
        exp_dst <= model(op_sel, pred_en, pred, src, old_dst);
        exp_tag <= {tag_of(op_sel, pred_en, pred, src), "/R9"};
      end else begin
        exp_tag <= "R9";
      end
    end
  end

  task automatic compare();
    n_vec++;
    if (out_valid !== exp_vld || dst !== exp_dst) begin
      n_bad++;
      $display("FAIL %s: out_valid=%b dst=%h expected out_valid=%b dst=%h",
               exp_tag, out_valid, dst, exp_vld, exp_dst);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] op, input logic pe,
      input logic [N-1:0] pr, input logic [N-1:0] s, input logic [N-1:0] old);
    @(negedge clk);
    compare();
    in_valid = v; op_sel = op; pred_en = pe; pred = pr; src = s; old_dst = old;
  endtask

  function automatic logic [N-1:0] rnd();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] ones = {N{1'b1}};
    repeat (3) begin @(negedge clk); compare(); end   // R10 reset state
    rst_n = 1'b1;

    for (int op = 0; op < 4; op++) begin
      // R4 empty source
      step(1, op[1:0], 0, '0, '0, 64'hA5A5_0F0F_3C3C_9999);
      // R1 R2 R3 first at element 0, at top element, mid
      step(1, op[1:0], 0, '0, 64'h1, '0);
      step(1, op[1:0], 0, '0, 64'h8000_0000_0000_0000, '0);
      step(1, op[1:0], 0, '0, 64'h0000_0100_0010_0000, ones);
      // R6 lowest bit hidden by predicate
      step(1, op[1:0], 1, ~64'h0000_0000_0000_0011, 64'h0000_0000_0000_0101, 64'h1234_5678_9ABC_DEF0);
      // R5 sparse predicate, no active source bit
      step(1, op[1:0], 1, 64'h00F0_0000_0000_000A, 64'h0F00_0000_0000_0005, ones);
      // R7 predicate ignored when disabled
      step(1, op[1:0], 0, 64'h0, 64'h0000_0000_0000_0400, '0);
      step(0, op[1:0], 0, rnd(), rnd(), rnd());          // R9 idle hold
      step(0, 2'b00, 0, rnd(), rnd(), rnd());
    end

    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] s = rnd();
      int sh = $urandom_range(0, 4);
      for (int j = 0; j < sh; j++) s = s & rnd();
      if ($urandom_range(0, 7) == 0) s = '0;
      step($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), rnd(), s, rnd());
    end
    step(0, 2'b00, 0, '0, '0, '0);
    step(0, 2'b00, 0, '0, '0, '0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule